// File: doc/BRIEF.md
# Atomic Access Local Lock Generator

This block drives the local-bus lock output while exclusive (locked) accesses pass from a PCI-style target port to a local bus. It watches the inbound frame and lock signals and a local access sequencer, which gives an address-phase strobe at the start of each local access and a done pulse in its final cycle. The first access of an atomic sequence asserts the active-low lock output in its own address cycle. The lock stays asserted until the initiator lets go of frame and lock in the same clock, and until at least one full clock has passed after the last local access has finished.

While the lock is held, every decoded target space counts as reserved for the locking initiator. These are memory space 0, memory space 1 and the expansion ROM space, together and not only the one that was addressed. An inbound request from any other initiator that hits one of these spaces raises a retry indication instead of being forwarded. A configuration bit enables locked operation. When it is clear, the lock output never asserts. Arbitration enforcement and the target state machine are outside this block.

Top module: `atomic_lock_gen`

## Requirements
- R1: After reset, `llockN` is 1, `spaceLocked` is all zeros and `retryReq` is 0.
- R2: When idle, with `lockEnable`=1 and `lockN`=0, an `addrStrobe` pulls `llockN` low in that same cycle.
- R3: An `addrStrobe` with `lockN`=1 while idle leaves `llockN` high.
- R4: While `lockEnable` is 0, `llockN` is 1 in every cycle, and a lock already held is dropped.
- R5: Once locked, seeing only one of `frameN`, `lockN` high, or neither, does not release the lock.
- R6: If `frameN` and `lockN` are both 1 in cycle t and no local access is outstanding, `llockN` stays low in cycles t and t+1 and goes high in cycle t+2.
- R7: If a local access is still outstanding when the release is seen, `llockN` stays low until its `accessDone` pulse in cycle d, stays low in d+1 and goes high in d+2. An access counts as outstanding from its `addrStrobe` up to and including its `accessDone` cycle. A strobe and done in the same cycle form a one-cycle access.
- R8: Every bit of `spaceLocked` equals the inverse of `llockN` in the same cycle. Bit 0 is memory space 0, bit 1 is memory space 1 and bit 2 is the expansion ROM.
- R9: `retryReq` is 1 exactly when the lock is active, `reqOwner`=0 and at least one bit of `reqHit` is set. `reqHit` uses the same bit order as `spaceLocked`. A request from the owner, or any request while unlocked, gives `retryReq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameN | input | 1 | Inbound frame, active low |
| lockN | input | 1 | Inbound lock, active low |
| addrStrobe | input | 1 | Local address phase of an access |
| accessDone | input | 1 | Final cycle of a local access |
| lockEnable | input | 1 | Locked-operation enable bit |
| reqHit | input | NUM_SPACES | One bit per decoded space that an inbound request hits |
| reqOwner | input | 1 | Inbound request comes from the locking initiator |
| llockN | output | 1 | Local lock, active low |
| spaceLocked | output | NUM_SPACES | Per-space reservation status |
| retryReq | output | 1 | Retry indication for a non-owner request |

## Verification
Two events can land in the same clock: the release (frame and lock both seen high) and the `accessDone` of the last local access. A release can also come while an access is still outstanding. Directed sequences put the done pulse before the release, on the same cycle as the release, and several cycles after it. The cycle in which `llockN` rises is then judged against the one-clock gap after the later of the two events. A seeded random stream adds overlapping strobes, done pulses, enable changes and requests from foreign initiators. Each cycle is compared with a bench model of the requirements.

// File: rtl/atomic_lock_pkg.sv
package atomic_lock_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_LOCKED  = 2'd1,
    ST_RELWAIT = 2'd2
  } lockState_t;

  // strobes passed from control to datapath
  typedef struct packed {
    logic assertNow;  // first address cycle of an atomic sequence
    logic held;       // lock state already entered
  } lockStrobes_t;

endpackage

// File: rtl/atomic_lock_ctrl.sv
module atomic_lock_ctrl
  import atomic_lock_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         frameN,
  input  logic         lockN,
  input  logic         addrStrobe,
  input  logic         lockEnable,
  input  logic         accessBusy,
  output lockStrobes_t sb
);

  lockState_t state, stateNext;
  logic startNow;
  logic releaseSeen;

  assign startNow    = (state == ST_IDLE) && lockEnable && addrStrobe && !lockN;
  assign releaseSeen = frameN && lockN;

  always_comb begin
    stateNext = state;
    if (!lockEnable) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:    if (startNow) stateNext = ST_LOCKED;
        ST_LOCKED:  if (releaseSeen) stateNext = ST_RELWAIT;
        ST_RELWAIT: if (!accessBusy) stateNext = ST_IDLE;
        default:    stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign sb.assertNow = startNow;
  assign sb.held      = (state != ST_IDLE);

  // R6
  release_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && lockEnable && frameN && lockN) |=> (state == ST_RELWAIT));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELWAIT && lockEnable && accessBusy) |=> (state != ST_IDLE));

  // R5
  no_early_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOCKED && lockEnable && !(frameN && lockN)) |=> (state == ST_LOCKED));

endmodule

// File: rtl/atomic_lock_path.sv
module atomic_lock_path
  import atomic_lock_pkg::*;
#(
  parameter int NUM_SPACES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  lockStrobes_t          sb,
  input  logic                  lockEnable,
  input  logic                  addrStrobe,
  input  logic                  accessDone,
  input  logic [NUM_SPACES-1:0] reqHit,
  input  logic                  reqOwner,
  output logic                  accessBusy,
  output logic                  llockN,
  output logic [NUM_SPACES-1:0] spaceLocked,
  output logic                  retryReq
);

  logic lockOn;
  logic anyHit;

  // outstanding local access tracker
  always_ff @(posedge clk) begin
    if (!rstN)           accessBusy <= 1'b0;
    else if (addrStrobe) accessBusy <= !accessDone;
    else if (accessDone) accessBusy <= 1'b0;
  end

  assign lockOn = lockEnable && (sb.assertNow || sb.held);
  assign llockN = !lockOn;

  for (genvar s = 0; s < NUM_SPACES; s++) begin : g_space
    assign spaceLocked[s] = lockOn;
  end

  assign anyHit   = |reqHit;
  assign retryReq = lockOn && !reqOwner && anyHit;

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lockEnable |-> (llockN && !retryReq));

  // R9
  retry_only_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    retryReq |-> (!llockN && !reqOwner));

  // R2
  start_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    sb.assertNow |=> sb.held);

  // R7
  busy_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrStrobe && !accessDone) |=> accessBusy);

endmodule

// File: rtl/atomic_lock_gen.sv
module atomic_lock_gen
  import atomic_lock_pkg::*;
#(
  parameter int NUM_SPACES = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameN,
  input  logic                  lockN,
  input  logic                  addrStrobe,
  input  logic                  accessDone,
  input  logic                  lockEnable,
  input  logic [NUM_SPACES-1:0] reqHit,
  input  logic                  reqOwner,
  output logic                  llockN,
  output logic [NUM_SPACES-1:0] spaceLocked,
  output logic                  retryReq
);

  lockStrobes_t sb;
  logic accessBusy;

  atomic_lock_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameN     (frameN),
    .lockN      (lockN),
    .addrStrobe (addrStrobe),
    .lockEnable (lockEnable),
    .accessBusy (accessBusy),
    .sb         (sb)
  );

  atomic_lock_path #(.NUM_SPACES(NUM_SPACES)) path_i (
    .clk         (clk),
    .rstN        (rstN),
    .sb          (sb),
    .lockEnable  (lockEnable),
    .addrStrobe  (addrStrobe),
    .accessDone  (accessDone),
    .reqHit      (reqHit),
    .reqOwner    (reqOwner),
    .accessBusy  (accessBusy),
    .llockN      (llockN),
    .spaceLocked (spaceLocked),
    .retryReq    (retryReq)
  );

endmodule

// File: tb/atomic_lock_gen_tb.sv
`timescale 1ns/1ps
module atomic_lock_gen_tb_top;

  localparam int NS = 3;

  logic clk = 1'b0;
  logic rstN;
  logic frameN, lockN, addrStrobe, accessDone, lockEnable, reqOwner;
  logic [NS-1:0] reqHit;
  logic llockN, retryReq;
  logic [NS-1:0] spaceLocked;

  int vecs = 0;
  int bad = 0;
  bit done = 0;

  // bench reference model: 0 idle, 1 locked, 2 release wait
  int  mState = 0;
  bit  mBusy = 0;

  always #2.5 clk = ~clk;

  atomic_lock_gen #(.NUM_SPACES(NS)) dut_i (
    .clk(clk), .rstN(rstN), .frameN(frameN), .lockN(lockN),
    .addrStrobe(addrStrobe), .accessDone(accessDone), .lockEnable(lockEnable),
    .reqHit(reqHit), .reqOwner(reqOwner), .llockN(llockN),
    .spaceLocked(spaceLocked), .retryReq(retryReq)
  );

  function automatic bit expOn();
    return lockEnable && (mState != 0 || (addrStrobe && !lockN));
  endfunction

  function automatic bit expRetry();
    return expOn() && !reqOwner && (|reqHit);
  endfunction

  function automatic void modelAdvance();
    int nxt;
    nxt = mState;
    if (!lockEnable) nxt = 0;
    else if (mState == 0 && addrStrobe && !lockN) nxt = 1;
    else if (mState == 1 && frameN && lockN) nxt = 2;
    else if (mState == 2 && !mBusy) nxt = 0;
    if (addrStrobe) mBusy = !accessDone;
    else if (accessDone) mBusy = 0;
    mState = nxt;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one cycle, compare all outputs with the model, advance the model
  task automatic step(input bit f, input bit l, input bit s, input bit d,
                      input bit e, input logic [NS-1:0] h, input bit o);
    @(negedge clk);
    frameN = f; lockN = l; addrStrobe = s; accessDone = d;
    lockEnable = e; reqHit = h; reqOwner = o;
    #1;
    chk(llockN == !expOn(), "R2/R5/R6/R7 llockN", llockN, !expOn());
    chk(spaceLocked == {NS{expOn()}}, "R8 spaceLocked", spaceLocked, {NS{expOn()}});
    chk(retryReq == expRetry(), "R9 retryReq", retryReq, expRetry());
    modelAdvance();
  endtask

  task automatic idleCycle();
    step(1, 1, 0, 0, 1, '0, 0);
  endtask

  initial begin
    void'($urandom(32'h1A7C_0042));
    rstN = 0; frameN = 1; lockN = 1; addrStrobe = 0; accessDone = 0;
    lockEnable = 1; reqHit = '0; reqOwner = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    // R1 reset state
    chk(llockN == 1'b1, "R1 llockN", llockN, 1);
    chk(spaceLocked == '0, "R1 spaceLocked", spaceLocked, 0);
    chk(retryReq == 1'b0, "R1 retryReq", retryReq, 0);

    // R2 + R6: lock start, short access, partial releases (R5), full release
    idleCycle();
    step(0, 0, 1, 0, 1, '0, 1);
    chk(llockN == 0, "R2 lock in address cycle", llockN, 0);
    step(0, 0, 0, 1, 1, '0, 1);
    step(1, 0, 0, 0, 1, '0, 1);
    chk(llockN == 0, "R5 frame only high", llockN, 0);
    step(0, 1, 0, 0, 1, '0, 1);
    chk(llockN == 0, "R5 lock only high", llockN, 0);
    // R9: foreign request to ROM space while locked
    step(0, 0, 0, 0, 1, 3'b100, 0);
    chk(retryReq == 1, "R9 foreign retry", retryReq, 1);
    step(0, 0, 0, 0, 1, 3'b001, 1);
    chk(retryReq == 0, "R9 owner no retry", retryReq, 0);
    step(1, 1, 0, 0, 1, '0, 0);           // release seen, cycle t
    chk(llockN == 0, "R6 cycle t", llockN, 0);
    idleCycle();
    chk(llockN == 0, "R6 cycle t+1", llockN, 0);
    idleCycle();
    chk(llockN == 1, "R6 cycle t+2", llockN, 1);
    step(1, 1, 0, 0, 1, 3'b010, 0);
    chk(retryReq == 0, "R9 unlocked no retry", retryReq, 0);

    // R7: release while access outstanding, done three cycles later
    step(0, 0, 1, 0, 1, '0, 1);
    step(1, 1, 0, 0, 1, '0, 0);
    idleCycle();
    idleCycle();
    chk(llockN == 0, "R7 held while busy", llockN, 0);
    step(1, 1, 0, 1, 1, '0, 0);           // done, cycle d
    chk(llockN == 0, "R7 cycle d", llockN, 0);
    idleCycle();
    chk(llockN == 0, "R7 cycle d+1", llockN, 0);
    idleCycle();
    chk(llockN == 1, "R7 cycle d+2", llockN, 1);

    // R7: done in the same cycle as the release
    step(0, 0, 1, 0, 1, '0, 1);
    step(1, 1, 0, 1, 1, '0, 0);
    idleCycle();
    chk(llockN == 0, "R7 coincident d+1", llockN, 0);
    idleCycle();
    chk(llockN == 1, "R7 coincident d+2", llockN, 1);

    // R3: plain access does not lock
    step(0, 1, 1, 1, 1, '0, 0);
    chk(llockN == 1, "R3 plain access", llockN, 1);
    idleCycle();
    chk(llockN == 1, "R3 after plain access", llockN, 1);

    // R4: disabled never locks; disabling drops a held lock
    step(0, 0, 1, 1, 0, 3'b011, 0);
    chk(llockN == 1, "R4 disabled start", llockN, 1);
    step(0, 0, 0, 0, 0, '0, 0);
    chk(llockN == 1, "R4 disabled next", llockN, 1);
    step(0, 0, 1, 1, 1, '0, 1);
    step(0, 0, 0, 0, 0, 3'b001, 0);
    chk(llockN == 1 && retryReq == 0, "R4 drop on disable", llockN, 1);
    idleCycle();
    idleCycle();

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      bit f, l, s, d, e, o;
      logic [NS-1:0] h;
      f = ($urandom_range(0, 3) == 0);
      l = ($urandom_range(0, 3) == 0);
      s = ($urandom_range(0, 4) == 0);
      d = ($urandom_range(0, 2) == 0);
      e = ($urandom_range(0, 19) != 0);
      h = NS'($urandom);
      o = $urandom_range(0, 1);
      step(f, l, s, d, e, h, o);
    end

    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

endmodule